// File: doc/BRIEF.md
# Timed Key-Check Unlock Sequencer

This block guards a private code store behind a fixed-length key. Once started from its idle (sub-command) state, it waits a fixed number of cycles and then takes whatever byte sits in the host-facing mailbox data register. It compares that byte against the matching entry of an internal key table, and repeats this for every key entry. There is no handshake. The host cannot signal that a byte is ready, so only a host that paces its writes to match the sampling rhythm gets through.

If the first compare fails, the sequencer posts a result byte to the mailbox. That byte holds the number of key entries still unchecked at the point of failure. It then posts a failure code to the mailbox status offset. If every entry matches, the sequencer copies the code store into shared RAM, one bank-sized chunk at a time. Before each chunk it selects the destination bank. After a settling pause it posts a pass code. On either outcome it pauses once more, pulses `done` and goes back to idle.

Top module: `key_unlock_seq`

## Requirements
- R1: After reset, and in every cycle while idle, `busy`, `done`, `mbx_we`, `bank_we`, `code_rd_en` and `sram_we` are all low.
- R2: `start` is acted on only while idle. A `start` pulse during a run changes neither the timing nor the content of any output of that run.
- R3: Key entry i (from 0) is compared with the value on `host_byte` at clock edge (i+1)*(SAMPLE_DELAY+1), counted from the edge that accepted `start`. `key_addr` presents i while that compare is pending. No handshake exists: a value the host left unchanged is compared as it stands.
- R4: On the first mismatch, at entry i, the cycle after the compare edge carries one mailbox write to offset 3 (result) with value KEY_LEN-1-i. The next cycle carries one mailbox write to offset 1 (status) with value 0x19. No bank select, code read or SRAM write occurs in that run.
- R5: After a full match the copy runs over NUM_BANKS chunks in ascending order. Each chunk opens with a one-cycle `bank_we` pulse carrying `bank_sel` = k. The first pulse falls in the cycle right after the last compare edge.
- R6: Byte j of chunk k takes a read cycle and then a write cycle. The read cycle has `code_rd_en` high with `code_addr` = CODE_BASE + k*BANK_BYTES + j. The write cycle has `sram_we` high with `sram_addr` = j and `sram_wdata` equal to the `code_rd_data` returned one cycle after the read. Bytes go in ascending order with no gaps.
- R7: After the last SRAM write come exactly SETTLE_DELAY quiet cycles, then one mailbox write of 0x18 to offset 1 (status).
- R8: After the status write of either outcome come exactly SETTLE_DELAY quiet cycles, then a one-cycle `done` pulse. The block is idle (`busy` low) in the following cycle.
- R9: In any cycle, at most one of `mbx_we`, `bank_we`, `code_rd_en` and `sram_we` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a key check (taken only while idle) |
| busy | output | 1 | High from the cycle after start until the return to idle |
| done | output | 1 | One-cycle pulse on the last cycle of a run |
| host_byte | input | 8 | Current content of the mailbox data register written by the host |
| mbx_we | output | 1 | Mailbox write strobe |
| mbx_addr | output | 2 | Mailbox offset: 1 status, 3 result |
| mbx_wdata | output | 8 | Mailbox write data |
| key_addr | output | $clog2(KEY_LEN) | Key table index, asynchronous read |
| key_data | input | 8 | Key table byte at `key_addr` |
| bank_we | output | 1 | Bank select update strobe |
| bank_sel | output | $clog2(NUM_BANKS) | Destination bank for the current chunk |
| code_rd_en | output | 1 | Code store read request |
| code_addr | output | CODE_AW | Code store read address |
| code_rd_data | input | 8 | Code store data, valid the cycle after `code_rd_en` |
| sram_we | output | 1 | Shared RAM write strobe |
| sram_addr | output | $clog2(BANK_BYTES) | Offset inside the selected bank |
| sram_wdata | output | 8 | Shared RAM write data |

## Verification
The bench builds the block with a four-entry key, a three-cycle sample delay, a five-cycle settle delay and two banks of four bytes. The code base is set to 0x24, which is not aligned to the copy size, so the adder form of the address generator is elaborated; the default parameters elaborate the OR form. These small values let every corrupted key position be swept, along with host pacing that is too fast, exact and too slow, and a host that never updates its byte. For each case the bench predicts the failing entry or a pass from the sampling arithmetic, then checks every mailbox, bank, read and write event against its computed cycle and value.

// File: rtl/keychk_pkg.sv
package keychk_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SAMPLE,
      ST_BANK,
      ST_READ,
      ST_WRITE,
      ST_SETTLE_OK,
      ST_POST_OK,
      ST_POST_CNT,
      ST_POST_BAD,
      ST_SETTLE_END,
      ST_DONE
   } seq_state_e;

   // mailbox offsets decoded by the host side
   localparam logic [1:0] MBX_STATUS = 2'd1;
   localparam logic [1:0] MBX_RESULT = 2'd3;

   // status codes
   localparam logic [7:0] CODE_PASS = 8'h18;
   localparam logic [7:0] CODE_FAIL = 8'h19;

endpackage

// File: rtl/kus_timer.sv
module kus_timer #(
   parameter int W = 9
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/kus_key_scan.sv
module kus_key_scan #(
   parameter int KEY_LEN = 128,
   localparam int IDX_W = $clog2(KEY_LEN)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [7:0]       host_byte,
   input  logic [7:0]       key_byte,
   output logic [IDX_W-1:0] idx,
   output logic             is_last,
   output logic             hit,
   output logic [7:0]       remaining
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_LEN - 1);
   localparam logic [7:0]       TOP_CNT  = 8'(KEY_LEN - 1);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clr) begin
         idx_q <= '0;
      end else if (adv) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign idx       = idx_q;
   assign is_last   = (idx_q == LAST_IDX);
   assign hit       = (host_byte == key_byte);
   assign remaining = TOP_CNT - 8'(idx_q);

   // R3: the index never runs past the end of the key table
   p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx_q) < KEY_LEN);

   // R3: advancing never happens on the last entry
   p_no_adv_past_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr) |-> !is_last);

endmodule

// File: rtl/kus_copy_engine.sv
module kus_copy_engine #(
   parameter int NUM_BANKS  = 8,
   parameter int BANK_BYTES = 1024,
   parameter int CODE_AW    = 14,
   parameter int CODE_BASE  = 8192,
   localparam int BK_W  = $clog2(NUM_BANKS),
   localparam int OFF_W = $clog2(BANK_BYTES)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               adv,
   output logic [BK_W-1:0]    bank,
   output logic [OFF_W-1:0]   offs,
   output logic [CODE_AW-1:0] code_addr,
   output logic               last_byte,
   output logic               last_bank
);

   localparam int LIN_W = BK_W + OFF_W;
   localparam logic [CODE_AW-1:0] BASE_V    = CODE_AW'(CODE_BASE);
   localparam logic [BK_W-1:0]    LAST_BANK = BK_W'(NUM_BANKS - 1);
   localparam logic [OFF_W-1:0]   LAST_OFF  = OFF_W'(BANK_BYTES - 1);

   logic [BK_W-1:0]  bank_q;
   logic [OFF_W-1:0] offs_q;
   logic [LIN_W-1:0] lin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= '0;
         offs_q <= '0;
      end else if (clr) begin
         bank_q <= '0;
         offs_q <= '0;
      end else if (adv) begin
         if (offs_q == LAST_OFF) begin
            offs_q <= '0;
            if (bank_q != LAST_BANK) begin
               bank_q <= bank_q + 1'b1;
            end
         end else begin
            offs_q <= offs_q + 1'b1;
         end
      end
   end

   // bank-size is a power of two, so concatenation equals k*BANK_BYTES+j
   assign lin = {bank_q, offs_q};

   generate
      if ((CODE_BASE % (1 << LIN_W)) == 0) begin : g_addr_or
         assign code_addr = BASE_V | CODE_AW'(lin);
      end else begin : g_addr_add
         assign code_addr = BASE_V + CODE_AW'(lin);
      end
   endgenerate

   assign bank      = bank_q;
   assign offs      = offs_q;
   assign last_byte = (offs_q == LAST_OFF);
   assign last_bank = (bank_q == LAST_BANK);

   // R5: the bank counter never leaves the configured range
   p_bank_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bank_q) < NUM_BANKS);

   // R6: the generated address stays inside the copied region
   p_addr_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(code_addr) >= CODE_BASE) &&
      (int'(code_addr) <  CODE_BASE + NUM_BANKS * BANK_BYTES));

endmodule

// File: rtl/key_unlock_seq.sv
module key_unlock_seq
   import keychk_pkg::*;
#(
   parameter int KEY_LEN      = 128,
   parameter int SAMPLE_DELAY = 384,
   parameter int SETTLE_DELAY = 3600,
   parameter int NUM_BANKS    = 8,
   parameter int BANK_BYTES   = 1024,
   parameter int CODE_AW      = 14,
   parameter int CODE_BASE    = 8192,
   localparam int IDX_W = $clog2(KEY_LEN),
   localparam int BK_W  = $clog2(NUM_BANKS),
   localparam int OFF_W = $clog2(BANK_BYTES)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               busy,
   output logic               done,
   input  logic [7:0]         host_byte,
   output logic               mbx_we,
   output logic [1:0]         mbx_addr,
   output logic [7:0]         mbx_wdata,
   output logic [IDX_W-1:0]   key_addr,
   input  logic [7:0]         key_data,
   output logic               bank_we,
   output logic [BK_W-1:0]    bank_sel,
   output logic               code_rd_en,
   output logic [CODE_AW-1:0] code_addr,
   input  logic [7:0]         code_rd_data,
   output logic               sram_we,
   output logic [OFF_W-1:0]   sram_addr,
   output logic [7:0]         sram_wdata
);

   localparam int DLY_MAX = (SAMPLE_DELAY > SETTLE_DELAY) ? SAMPLE_DELAY : SETTLE_DELAY;
   localparam int DLY_W   = $clog2(DLY_MAX + 1);
   localparam logic [DLY_W-1:0] SAMPLE_LD = DLY_W'(SAMPLE_DELAY - 1);
   localparam logic [DLY_W-1:0] SETTLE_LD = DLY_W'(SETTLE_DELAY - 1);

   // elaboration-time parameter checks
   generate
      if (KEY_LEN < 2 || KEY_LEN > 256) begin : g_bad_key_len
         $error("KEY_LEN must lie in 2..256");
      end
      if (SAMPLE_DELAY < 1 || SETTLE_DELAY < 1) begin : g_bad_delay
         $error("delays must be at least one cycle");
      end
      if (NUM_BANKS < 2) begin : g_bad_banks
         $error("NUM_BANKS must be at least 2");
      end
      if (BANK_BYTES < 2 || (BANK_BYTES & (BANK_BYTES - 1)) != 0) begin : g_bad_bank_bytes
         $error("BANK_BYTES must be a power of two, at least 2");
      end
      if (CODE_BASE < 0 || CODE_BASE + NUM_BANKS * BANK_BYTES > (1 << CODE_AW)) begin : g_bad_code_map
         $error("code store does not fit in CODE_AW address bits");
      end
   endgenerate

   seq_state_e state_q, state_d;

   logic             tmr_load;
   logic [DLY_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             scan_clr, scan_adv, key_hit, key_last;
   logic [7:0]       key_left;
   logic             eng_clr, eng_adv, byte_last, bank_last;
   logic [OFF_W-1:0] eng_off;
   logic [BK_W-1:0]  eng_bank;

   kus_timer #(.W(DLY_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   kus_key_scan #(.KEY_LEN(KEY_LEN)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (scan_clr),
      .adv       (scan_adv),
      .host_byte (host_byte),
      .key_byte  (key_data),
      .idx       (key_addr),
      .is_last   (key_last),
      .hit       (key_hit),
      .remaining (key_left)
   );

   kus_copy_engine #(
      .NUM_BANKS  (NUM_BANKS),
      .BANK_BYTES (BANK_BYTES),
      .CODE_AW    (CODE_AW),
      .CODE_BASE  (CODE_BASE)
   ) u_copy (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (eng_clr),
      .adv       (eng_adv),
      .bank      (eng_bank),
      .offs      (eng_off),
      .code_addr (code_addr),
      .last_byte (byte_last),
      .last_bank (bank_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = SAMPLE_LD;
      scan_clr = 1'b0;
      scan_adv = 1'b0;
      eng_clr  = 1'b0;
      eng_adv  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d  = ST_WAIT;
               tmr_load = 1'b1;
               scan_clr = 1'b1;
               eng_clr  = 1'b1;
            end
         end
         ST_WAIT: begin
            if (tmr_zero) state_d = ST_SAMPLE;
         end
         ST_SAMPLE: begin
            if (!key_hit) begin
               state_d = ST_POST_CNT;
            end else if (key_last) begin
               state_d = ST_BANK;
            end else begin
               scan_adv = 1'b1;
               tmr_load = 1'b1;
               state_d  = ST_WAIT;
            end
         end
         ST_BANK: state_d = ST_READ;
         ST_READ: state_d = ST_WRITE;
         ST_WRITE: begin
            eng_adv = 1'b1;
            if (!byte_last) begin
               state_d = ST_READ;
            end else if (!bank_last) begin
               state_d = ST_BANK;
            end else begin
               state_d  = ST_SETTLE_OK;
               tmr_load = 1'b1;
               tmr_val  = SETTLE_LD;
            end
         end
         ST_SETTLE_OK: begin
            if (tmr_zero) state_d = ST_POST_OK;
         end
         ST_POST_OK, ST_POST_BAD: begin
            state_d  = ST_SETTLE_END;
            tmr_load = 1'b1;
            tmr_val  = SETTLE_LD;
         end
         ST_POST_CNT: state_d = ST_POST_BAD;
         ST_SETTLE_END: begin
            if (tmr_zero) state_d = ST_DONE;
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   // output decode
   always_comb begin
      mbx_we    = 1'b0;
      mbx_addr  = MBX_STATUS;
      mbx_wdata = 8'h00;
      unique case (state_q)
         ST_POST_OK: begin
            mbx_we    = 1'b1;
            mbx_wdata = CODE_PASS;
         end
         ST_POST_CNT: begin
            mbx_we    = 1'b1;
            mbx_addr  = MBX_RESULT;
            mbx_wdata = key_left;
         end
         ST_POST_BAD: begin
            mbx_we    = 1'b1;
            mbx_wdata = CODE_FAIL;
         end
         default: begin
            mbx_we = 1'b0;
         end
      endcase
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = (state_q == ST_DONE);
   assign bank_we    = (state_q == ST_BANK);
   assign bank_sel   = eng_bank;
   assign code_rd_en = (state_q == ST_READ);
   assign sram_we    = (state_q == ST_WRITE);
   assign sram_addr  = eng_off;
   assign sram_wdata = code_rd_data;

   // ---------------- assertions ----------------

   // cycles since the last start or sample, saturating
   logic [DLY_W:0] a_gap;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_gap <= '0;
      end else if ((state_q == ST_IDLE && start) || state_q == ST_SAMPLE) begin
         a_gap <= '0;
      end else if (a_gap != '1) begin
         a_gap <= a_gap + 1'b1;
      end
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mbx_we || sram_we || code_rd_en || bank_we || done));

   p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   p_sample_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SAMPLE) |-> (int'(a_gap) == SAMPLE_DELAY));

   p_result_then_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mbx_we && mbx_addr == MBX_RESULT) |=>
         (mbx_we && mbx_addr == MBX_STATUS && mbx_wdata == CODE_FAIL));

   p_bank_then_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |=> (code_rd_en && $stable(bank_sel)));

   p_read_then_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      code_rd_en |=> (sram_we && sram_addr == $past(code_addr[OFF_W-1:0])));

   p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we |-> $past(code_rd_en));

   p_pass_after_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mbx_we && mbx_wdata == CODE_PASS) |-> $past(state_q == ST_SETTLE_OK && tmr_zero));

   p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mbx_we, sram_we, code_rd_en, bank_we}));

endmodule

// File: tb/key_unlock_seq_tb.sv
module key_unlock_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int K   = 4;
   localparam int D   = 3;
   localparam int S   = 5;
   localparam int NB  = 2;
   localparam int BB  = 4;
   localparam int CAW = 8;
   localparam int CB  = 36;
   localparam int IW  = $clog2(K);
   localparam int BW  = $clog2(NB);
   localparam int OW  = $clog2(BB);
   localparam int T0  = K * (D + 1);
   localparam int TW  = T0 + NB * (1 + 2 * BB) - 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [7:0]     host_byte = 8'h00;
   logic           busy, done, mbx_we, bank_we, code_rd_en, sram_we;
   logic [1:0]     mbx_addr;
   logic [7:0]     mbx_wdata, sram_wdata;
   logic [IW-1:0]  key_addr;
   logic [7:0]     key_data;
   logic [BW-1:0]  bank_sel;
   logic [CAW-1:0] code_addr;
   logic [7:0]     code_rd_data = 8'h00;
   logic [OW-1:0]  sram_addr;

   key_unlock_seq #(
      .KEY_LEN(K), .SAMPLE_DELAY(D), .SETTLE_DELAY(S),
      .NUM_BANKS(NB), .BANK_BYTES(BB), .CODE_AW(CAW), .CODE_BASE(CB)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .host_byte(host_byte), .mbx_we(mbx_we), .mbx_addr(mbx_addr),
      .mbx_wdata(mbx_wdata), .key_addr(key_addr), .key_data(key_data),
      .bank_we(bank_we), .bank_sel(bank_sel), .code_rd_en(code_rd_en),
      .code_addr(code_addr), .code_rd_data(code_rd_data), .sram_we(sram_we),
      .sram_addr(sram_addr), .sram_wdata(sram_wdata)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;

   // scenario state
   logic [7:0] kbase = 8'h3C;
   logic [7:0] kstep = 8'h11;
   int bad_idx = K;
   int host_per = D + 1;
   int ef, n0, t, k, j;
   int nwr, nrd, nbk, nmb, ndone;
   logic run_on = 1'b0;

   function automatic logic [7:0] codef(input int a);
      return 8'(a * 7) ^ 8'h5A;
   endfunction

   function automatic logic [7:0] keyv(input int i);
      return kbase + 8'(i) * kstep;
   endfunction

   function automatic logic [7:0] hostv(input int m);
      return keyv(m) ^ ((m == bad_idx) ? 8'hFF : 8'h00);
   endfunction

   // index of the first failing compare, K for a pass
   function automatic int exp_fail_at();
      for (int i = 0; i < K; i++) begin
         int e, m;
         e = (i + 1) * (D + 1);
         m = (e - 1) / host_per;
         if (m > K - 1) m = K - 1;
         if (hostv(m) != keyv(i)) return i;
      end
      return K;
   endfunction

   // key table and code store models
   always_comb key_data = kbase + 8'(key_addr) * kstep;
   always @(posedge clk) if (code_rd_en) code_rd_data <= codef(int'(code_addr));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // event monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (run_on) begin
         t = cyc - n0;
         if ((int'(mbx_we) + int'(sram_we) + int'(code_rd_en) + int'(bank_we)) > 0)
            chk("R9 single strobe",
                ((int'(mbx_we) + int'(sram_we) + int'(code_rd_en) + int'(bank_we)) > 1) ? 1 : 0, 0);
         if (bank_we) begin
            chk("R5 bank pulse cycle", t, T0 + nbk * (1 + 2 * BB));
            chk("R5 bank index", int'(bank_sel), nbk);
            nbk++;
         end
         if (code_rd_en) begin
            k = nrd / BB;
            j = nrd % BB;
            chk("R6 read cycle", t, T0 + k * (1 + 2 * BB) + 1 + 2 * j);
            chk("R6 read address", int'(code_addr), CB + k * BB + j);
            nrd++;
         end
         if (sram_we) begin
            k = nwr / BB;
            j = nwr % BB;
            chk("R4 copy only on full match", int'(ef == K), 1);
            chk("R6 write cycle", t, T0 + k * (1 + 2 * BB) + 2 + 2 * j);
            chk("R6 write offset", int'(sram_addr), j);
            chk("R6 write data", int'(sram_wdata), int'(codef(CB + k * BB + j)));
            chk("R5 bank held during chunk", int'(bank_sel), k);
            nwr++;
         end
         if (mbx_we) begin
            if (ef == K) begin
               chk("R7 pass status cycle", t, TW + S + 1);
               chk("R7 pass status offset", int'(mbx_addr), 1);
               chk("R7 pass code", int'(mbx_wdata), 'h18);
            end else if (nmb == 0) begin
               chk("R4 result cycle", t, (ef + 1) * (D + 1));
               chk("R4 result offset", int'(mbx_addr), 3);
               chk("R4 remaining count", int'(mbx_wdata), K - 1 - ef);
            end else begin
               chk("R4 fail status cycle", t, (ef + 1) * (D + 1) + 1);
               chk("R4 fail status offset", int'(mbx_addr), 1);
               chk("R4 fail code", int'(mbx_wdata), 'h19);
            end
            nmb++;
         end
         if (done) begin
            chk("R8 done cycle", t, (ef == K) ? (TW + 2 * S + 2) : ((ef + 1) * (D + 1) + S + 2));
            ndone++;
         end
      end
   end

   task automatic run(input int per, input int bad, input logic [7:0] kb, input logic [7:0] ks);
      int w;
      host_per = per;
      bad_idx  = bad;
      kbase    = kb;
      kstep    = ks;
      ef = exp_fail_at();
      nwr = 0; nrd = 0; nbk = 0; nmb = 0; ndone = 0;
      @(negedge clk);
      start = 1'b1;
      host_byte = hostv(0);
      @(posedge clk);
      #1;
      n0 = cyc;
      run_on = 1'b1;
      start = 1'b0;
      for (int m = 1; m < K; m++) begin
         repeat (per) @(posedge clk);
         #1;
         host_byte = hostv(m);
      end
      // R2: a start pulse while busy must leave the run untouched
      @(negedge clk);
      if (busy) begin
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      w = 0;
      while (ndone == 0 && w < 2000) begin
         @(negedge clk);
         w++;
      end
      repeat (3) @(negedge clk);
      run_on = 1'b0;
      chk("R8 idle after done", int'(busy), 0);
      chk("R2 R8 exactly one done", ndone, 1);
      chk("R3 outcome matches sampling", int'(nwr != 0), int'(ef == K));
      if (ef == K) begin
         chk("R6 write count", nwr, NB * BB);
         chk("R5 bank count", nbk, NB);
         chk("R7 status write count", nmb, 1);
      end else begin
         chk("R4 no bank select", nbk, 0);
         chk("R4 no code read", nrd, 0);
         chk("R4 mailbox write count", nmb, 2);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL R8 watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset busy", int'(busy), 0);
      chk("R1 reset done", int'(done), 0);
      chk("R1 reset mailbox write", int'(mbx_we), 0);
      chk("R1 reset bank select", int'(bank_we), 0);
      chk("R1 reset code read", int'(code_rd_en), 0);
      chk("R1 reset sram write", int'(sram_we), 0);

      // host pacing fast / exact / slow, every corrupted position and none
      for (int p = D; p <= D + 2; p++) begin
         for (int b = 0; b <= K; b++) begin
            run(p, b, 8'h3C, 8'h11);
         end
      end
      // R3: host never updates; constant key passes, varying key fails at 1
      run(100, K, 8'hA7, 8'h00);
      run(100, K, 8'hA7, 8'h05);

      // R1: idle again with no activity
      repeat (5) @(negedge clk);
      chk("R1 quiet idle busy", int'(busy), 0);
      chk("R1 quiet idle strobes", int'(mbx_we | sram_we | code_rd_en | bank_we), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule